// File: doc/BRIEF.md
# Protected PLL Control Register Unit

This block is an APB slave holding the run-time settings of a clock multiplier: an enable bit, a connect bit, a pre-divider field and a multiplier field. Software writes to the control and configuration registers land only in shadow copies. The active copies, which drive the multiplier, change only when software writes a two-value unlock key to a feed register as two back-to-back bus transfers. A stray write therefore cannot retune or switch the system clock. The same applies to a half-finished unlock that an interrupt breaks.

The unit also watches a lock status input and a power-down request input. Power-down forces the active enable and connect bits low. Waking up does not restore them; software must program them again and repeat the unlock. A connect request takes effect only when the multiplier was already enabled before that unlock and lock is high. Because of this, one feed cannot enable and connect at the same time. The pre-divider and multiplier outputs are the stored fields plus one.

Top module: `pllg_top`

## Requirements
- R1: After reset, pll_enable and pll_connect are 0, pll_prediv and pll_mult are 1, and reads of every register return the reset values (status bits 1:0 read 0).
- R2: A write to CTRL (offset 0x0; bit 0 enable, bit 1 connect) or to CFG (offset 0x4; multiplier field bits 14:0, pre-divider field bits 20:16) changes no output until a valid feed.
- R3: Writing 0xAA and then 0x55 in bits 7:0 to FEED (offset 0x8), as two APB transfers with no other transfer between them, copies all shadow values to the active registers at the clock edge that completes the 0x55 write.
- R4: Any other APB transfer (read or write, any offset) between the 0xAA and 0x55 feed writes aborts the sequence; the active values stay unchanged.
- R5: A feed write of any value other than 0xAA or 0x55 in the sequence returns the checker to idle, and no shadow values are applied.
- R6: Shadow registers keep their contents after a failed feed; a later correct feed applies them.
- R7: On a valid feed, active connect becomes 1 only if the shadow connect and enable bits are 1, the active enable was already 1 before that feed, and pll_lock is high; otherwise active connect becomes 0.
- R8: While pd_req is high, active enable and connect are cleared at each clock edge (taking priority over a feed); after pd_req falls they stay 0 until a new feed.
- R9: pll_prediv equals the active pre-divider field plus one (1 to 32), and pll_mult equals the active multiplier field plus one.
- R10: Reads of CTRL and CFG return the active values in the write layout; reads of FEED return 0; STATUS (offset 0xC) reads bit 0 active enable, bit 1 active connect, bit 2 pll_lock.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| pclk | input | 1 | APB clock |
| presetn | input | 1 | Asynchronous active-low reset, released synchronously inside |
| psel | input | 1 | APB select |
| penable | input | 1 | APB access phase |
| pwrite | input | 1 | APB write (1) or read (0) |
| paddr | input | 4 | APB byte address |
| pwdata | input | 32 | APB write data |
| prdata | output | 32 | APB read data, valid during the access phase of a read |
| pll_lock | input | 1 | Lock status from the multiplier |
| pd_req | input | 1 | Power-down request |
| pll_enable | output | 1 | Active enable |
| pll_connect | output | 1 | Active connect |
| pll_prediv | output | 6 | Pre-divider value, field plus one |
| pll_mult | output | 16 | Multiplier value, field plus one |

## Verification
Shadow writes and the feed checker update at the rising edge that ends an APB access phase. The active outputs therefore change at the edge that completes the 0x55 feed write and are sampled at the falling edge after it. A power-down pulse takes effect at the next rising edge, and the bench checks its outputs one half cycle later. Read data comes directly from the active registers, so the bench samples prdata at the falling edge inside the access phase, before the completing edge.

// File: rtl/pllg_pkg.sv
package pllg_pkg;

  typedef enum logic {
    FS_IDLE  = 1'b0,
    FS_ARMED = 1'b1
  } feed_state_e;

  localparam logic [7:0] KEY_FIRST  = 8'hAA;
  localparam logic [7:0] KEY_SECOND = 8'h55;

  localparam int OFS_CTRL = 0;
  localparam int OFS_CFG  = 4;
  localparam int OFS_FEED = 8;
  localparam int OFS_STAT = 12;

  localparam int BIT_EN   = 0;
  localparam int BIT_CONN = 1;
  localparam int BIT_LOCK = 2;

endpackage

// File: rtl/pllg_rst_sync.sv
module pllg_rst_sync #(
  parameter int STAGES = 2
) (
  input  logic clk,
  input  logic arst_n,
  output logic rst_n
);

  logic [STAGES-1:0] chain_q;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      chain_q <= '0;
    end else begin
      chain_q <= {chain_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_n = chain_q[STAGES-1];

endmodule

// File: rtl/pllg_apb_decode.sv
module pllg_apb_decode
  import pllg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int NSEL_W   = 5,
  parameter int MSEL_W   = 15,
  parameter int NSEL_LSB = 16
) (
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic              act_en,
  input  logic              act_conn,
  input  logic              lock,
  input  logic [NSEL_W-1:0] act_nsel,
  input  logic [MSEL_W-1:0] act_msel,
  output logic              xfer,
  output logic              wr_ctrl,
  output logic              wr_cfg,
  output logic              wr_feed,
  output logic [DATA_W-1:0] prdata
);

  localparam logic [ADDR_W-1:0] A_CTRL = ADDR_W'(OFS_CTRL);
  localparam logic [ADDR_W-1:0] A_CFG  = ADDR_W'(OFS_CFG);
  localparam logic [ADDR_W-1:0] A_STAT = ADDR_W'(OFS_STAT);
  localparam logic [ADDR_W-1:0] A_FEED = ADDR_W'(OFS_FEED);

  logic do_wr;

  assign xfer    = psel && penable;
  assign do_wr   = xfer && pwrite;
  assign wr_ctrl = do_wr && (paddr == A_CTRL);
  assign wr_cfg  = do_wr && (paddr == A_CFG);
  assign wr_feed = do_wr && (paddr == A_FEED);

  always_comb begin
    prdata = '0;
    if (psel && !pwrite) begin
      unique case (paddr)
        A_CTRL: begin
          prdata[BIT_EN]   = act_en;
          prdata[BIT_CONN] = act_conn;
        end
        A_CFG: begin
          prdata[MSEL_W-1:0]          = act_msel;
          prdata[NSEL_LSB +: NSEL_W]  = act_nsel;
        end
        A_STAT: begin
          prdata[BIT_EN]   = act_en;
          prdata[BIT_CONN] = act_conn;
          prdata[BIT_LOCK] = lock;
        end
        default: prdata = '0;
      endcase
    end
  end

endmodule

// File: rtl/pllg_feed_seq.sv
module pllg_feed_seq
  import pllg_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       xfer,
  input  logic       wr_feed,
  input  logic [7:0] key,
  output logic       fire
);

  feed_state_e st_q, st_d;

  always_comb begin
    st_d = st_q;
    fire = 1'b0;
    if (xfer) begin
      if (wr_feed) begin
        if ((st_q == FS_ARMED) && (key == KEY_SECOND)) begin
          fire = 1'b1;
          st_d = FS_IDLE;
        end else if (key == KEY_FIRST) begin
          st_d = FS_ARMED;
        end else begin
          st_d = FS_IDLE;
        end
      end else begin
        st_d = FS_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= FS_IDLE;
    end else begin
      st_q <= st_d;
    end
  end

  // R4: any non-feed transfer leaves the checker idle
  p_other_xfer_aborts_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && !wr_feed) |=> (st_q == FS_IDLE));

  // R5: a feed value outside the key pair leaves the checker idle
  p_bad_key_idles_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && wr_feed && (key != KEY_FIRST) && (key != KEY_SECOND)) |=> (st_q == FS_IDLE));

  // R3: the first key arms the checker
  p_first_key_arms_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (xfer && wr_feed && (key == KEY_FIRST)) |=> (st_q == FS_ARMED));

endmodule

// File: rtl/pllg_cfg_regs.sv
module pllg_cfg_regs
  import pllg_pkg::*;
#(
  parameter int DATA_W   = 32,
  parameter int NSEL_W   = 5,
  parameter int MSEL_W   = 15,
  parameter int NSEL_LSB = 16
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_ctrl,
  input  logic              wr_cfg,
  input  logic [DATA_W-1:0] wdata,
  input  logic              fire,
  input  logic              lock,
  input  logic              pd,
  output logic              act_en,
  output logic              act_conn,
  output logic [NSEL_W-1:0] act_nsel,
  output logic [MSEL_W-1:0] act_msel
);

  logic              sh_en_q, sh_conn_q;
  logic [NSEL_W-1:0] sh_nsel_q;
  logic [MSEL_W-1:0] sh_msel_q;

  logic              en_q, en_d, conn_q, conn_d;
  logic [NSEL_W-1:0] nsel_q, nsel_d;
  logic [MSEL_W-1:0] msel_q, msel_d;

  // Shadow copies, written by software, clock-enabled per register
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_en_q   <= 1'b0;
      sh_conn_q <= 1'b0;
    end else if (wr_ctrl) begin
      sh_en_q   <= wdata[BIT_EN];
      sh_conn_q <= wdata[BIT_CONN];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sh_nsel_q <= '0;
      sh_msel_q <= '0;
    end else if (wr_cfg) begin
      sh_nsel_q <= wdata[NSEL_LSB +: NSEL_W];
      sh_msel_q <= wdata[MSEL_W-1:0];
    end
  end

  // Active copies: next state
  always_comb begin
    en_d   = en_q;
    conn_d = conn_q;
    nsel_d = nsel_q;
    msel_d = msel_q;
    if (fire) begin
      en_d   = sh_en_q;
      conn_d = sh_conn_q && sh_en_q && en_q && lock;
      nsel_d = sh_nsel_q;
      msel_d = sh_msel_q;
    end
    if (pd) begin
      en_d   = 1'b0;
      conn_d = 1'b0;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      en_q   <= 1'b0;
      conn_q <= 1'b0;
      nsel_q <= '0;
      msel_q <= '0;
    end else begin
      en_q   <= en_d;
      conn_q <= conn_d;
      nsel_q <= nsel_d;
      msel_q <= msel_d;
    end
  end

  assign act_en   = en_q;
  assign act_conn = conn_q;
  assign act_nsel = nsel_q;
  assign act_msel = msel_q;

  // R2: without a feed the active configuration holds
  p_cfg_hold_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !fire |=> ($stable(nsel_q) && $stable(msel_q)));

  // R8: power-down clears enable and connect at the next edge
  p_pd_clears_r8: assert property (@(posedge clk) disable iff (!rst_n)
    pd |=> (!en_q && !conn_q));

  // R7: connect never stands without enable
  p_conn_needs_en_r7: assert property (@(posedge clk) disable iff (!rst_n)
    conn_q |-> en_q);

  // R7: connect rises only with lock and a prior enable
  p_conn_rise_lock_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(conn_q) |-> ($past(lock) && $past(en_q) && $past(fire)));

endmodule

// File: rtl/pllg_top.sv
module pllg_top
  import pllg_pkg::*;
#(
  parameter int ADDR_W   = 4,
  parameter int DATA_W   = 32,
  parameter int NSEL_W   = 5,
  parameter int MSEL_W   = 15,
  parameter int NSEL_LSB = 16,
  localparam int PDIV_W  = NSEL_W + 1,
  localparam int MULT_W  = MSEL_W + 1
) (
  input  logic              pclk,
  input  logic              presetn,
  input  logic              psel,
  input  logic              penable,
  input  logic              pwrite,
  input  logic [ADDR_W-1:0] paddr,
  input  logic [DATA_W-1:0] pwdata,
  output logic [DATA_W-1:0] prdata,
  input  logic              pll_lock,
  input  logic              pd_req,
  output logic              pll_enable,
  output logic              pll_connect,
  output logic [PDIV_W-1:0] pll_prediv,
  output logic [MULT_W-1:0] pll_mult
);

  logic              rst_n;
  logic              xfer, wr_ctrl, wr_cfg, wr_feed, fire;
  logic              act_en, act_conn;
  logic [NSEL_W-1:0] act_nsel;
  logic [MSEL_W-1:0] act_msel;

  pllg_rst_sync #(.STAGES(2)) u_rst (
    .clk    (pclk),
    .arst_n (presetn),
    .rst_n  (rst_n)
  );

  pllg_apb_decode #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .NSEL_W(NSEL_W),
    .MSEL_W(MSEL_W), .NSEL_LSB(NSEL_LSB)
  ) u_dec (
    .psel     (psel),
    .penable  (penable),
    .pwrite   (pwrite),
    .paddr    (paddr),
    .act_en   (act_en),
    .act_conn (act_conn),
    .lock     (pll_lock),
    .act_nsel (act_nsel),
    .act_msel (act_msel),
    .xfer     (xfer),
    .wr_ctrl  (wr_ctrl),
    .wr_cfg   (wr_cfg),
    .wr_feed  (wr_feed),
    .prdata   (prdata)
  );

  pllg_feed_seq u_feed (
    .clk     (pclk),
    .rst_n   (rst_n),
    .xfer    (xfer),
    .wr_feed (wr_feed),
    .key     (pwdata[7:0]),
    .fire    (fire)
  );

  pllg_cfg_regs #(
    .DATA_W(DATA_W), .NSEL_W(NSEL_W), .MSEL_W(MSEL_W), .NSEL_LSB(NSEL_LSB)
  ) u_regs (
    .clk      (pclk),
    .rst_n    (rst_n),
    .wr_ctrl  (wr_ctrl),
    .wr_cfg   (wr_cfg),
    .wdata    (pwdata),
    .fire     (fire),
    .lock     (pll_lock),
    .pd       (pd_req),
    .act_en   (act_en),
    .act_conn (act_conn),
    .act_nsel (act_nsel),
    .act_msel (act_msel)
  );

  assign pll_enable  = act_en;
  assign pll_connect = act_conn;
  assign pll_prediv  = PDIV_W'(act_nsel) + PDIV_W'(1);
  assign pll_mult    = MULT_W'(act_msel) + MULT_W'(1);

  // R10: the feed register always reads as zero
  p_feed_reads_zero_r10: assert property (@(posedge pclk) disable iff (!rst_n)
    (psel && !pwrite && (paddr == ADDR_W'(OFS_FEED))) |-> (prdata == '0));

  // R9: output values are never zero
  p_div_nonzero_r9: assert property (@(posedge pclk) disable iff (!rst_n)
    (pll_prediv != '0) && (pll_mult != '0));

endmodule

// File: tb/pllg_top_test.sv
`timescale 1ns/1ps
module pllg_top_test;

  logic        pclk = 1'b0;
  logic        presetn;
  logic        psel, penable, pwrite;
  logic [3:0]  paddr;
  logic [31:0] pwdata;
  logic [31:0] prdata;
  logic        pll_lock, pd_req;
  logic        pll_enable, pll_connect;
  logic [5:0]  pll_prediv;
  logic [15:0] pll_mult;

  int total = 0;
  int fails = 0;
  bit done  = 1'b0;

  always #5 pclk = ~pclk;

  pllg_top uut (
    .pclk(pclk), .presetn(presetn), .psel(psel), .penable(penable),
    .pwrite(pwrite), .paddr(paddr), .pwdata(pwdata), .prdata(prdata),
    .pll_lock(pll_lock), .pd_req(pd_req), .pll_enable(pll_enable),
    .pll_connect(pll_connect), .pll_prediv(pll_prediv), .pll_mult(pll_mult)
  );

  localparam logic [3:0] A_CTRL = 4'h0, A_CFG = 4'h4, A_FEED = 4'h8, A_STAT = 4'hC;

  function automatic logic [31:0] cfg_word(input int nsel, input int msel);
    return (32'(nsel & 31) << 16) | 32'(msel & 32'h7FFF);
  endfunction

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    total++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: actual 0x%0h expected 0x%0h", tag, act, exp);
    end
  endtask

  task automatic apb_wr(input logic [3:0] a, input logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 1; paddr = a; pwdata = d;
    @(negedge pclk); penable = 1;
    @(negedge pclk); psel = 0; penable = 0; pwrite = 0;
  endtask

  task automatic apb_rd(input logic [3:0] a, output logic [31:0] d);
    @(negedge pclk); psel = 1; penable = 0; pwrite = 0; paddr = a;
    @(negedge pclk); penable = 1; #1 d = prdata;
    @(negedge pclk); psel = 0; penable = 0;
  endtask

  task automatic feed();
    apb_wr(A_FEED, 32'hAA);
    apb_wr(A_FEED, 32'h55);
  endtask

  task automatic t_reset();
    logic [31:0] r;
    chk("R1 enable", 32'(pll_enable), 0);
    chk("R1 connect", 32'(pll_connect), 0);
    chk("R1 prediv", 32'(pll_prediv), 1);
    chk("R1 mult", 32'(pll_mult), 1);
    apb_rd(A_STAT, r); chk("R1 status", r, 0);
    apb_rd(A_CFG, r);  chk("R1 cfg read", r, 0);
  endtask

  task automatic t_shadow();
    logic [31:0] r;
    apb_wr(A_CTRL, 32'h1);
    apb_wr(A_CFG, cfg_word(3, 9));
    chk("R2 enable held", 32'(pll_enable), 0);
    chk("R2 prediv held", 32'(pll_prediv), 1);
    chk("R2 mult held", 32'(pll_mult), 1);
    apb_rd(A_CTRL, r); chk("R10 ctrl reads active", r, 0);
  endtask

  task automatic t_feed();
    logic [31:0] r;
    feed();
    chk("R3 enable applied", 32'(pll_enable), 1);
    chk("R9 prediv", 32'(pll_prediv), 4);
    chk("R9 mult", 32'(pll_mult), 10);
    chk("R7 no connect requested", 32'(pll_connect), 0);
    apb_rd(A_CFG, r); chk("R10 cfg reads active", r, cfg_word(3, 9));
  endtask

  task automatic t_abort();
    logic [31:0] r;
    apb_wr(A_CFG, cfg_word(31, 32'h7FFF));
    apb_wr(A_FEED, 32'hAA);
    apb_rd(A_STAT, r);
    apb_wr(A_FEED, 32'h55);
    chk("R4 prediv after aborted feed", 32'(pll_prediv), 4);
    apb_wr(A_FEED, 32'hAA);
    apb_wr(A_CTRL, 32'h1);
    apb_wr(A_FEED, 32'h55);
    chk("R4 mult after write-aborted feed", 32'(pll_mult), 10);
  endtask

  task automatic t_badval();
    apb_wr(A_FEED, 32'hAA);
    apb_wr(A_FEED, 32'h56);
    apb_wr(A_FEED, 32'h55);
    chk("R5 prediv after wrong key", 32'(pll_prediv), 4);
    apb_wr(A_FEED, 32'h54);
    apb_wr(A_FEED, 32'h55);
    chk("R5 mult after wrong first key", 32'(pll_mult), 10);
    feed();
    chk("R6 R9 prediv max", 32'(pll_prediv), 32);
    chk("R6 R9 mult max", 32'(pll_mult), 32'h8000);
  endtask

  task automatic t_connect();
    logic [31:0] r;
    pll_lock = 0;
    apb_wr(A_CTRL, 32'h3);
    feed();
    chk("R7 no connect without lock", 32'(pll_connect), 0);
    pll_lock = 1;
    feed();
    chk("R7 connect with lock", 32'(pll_connect), 1);
    apb_rd(A_STAT, r); chk("R10 status", r, 32'h7);
    apb_rd(A_FEED, r); chk("R10 feed reads zero", r, 0);
    apb_rd(A_CTRL, r); chk("R10 ctrl reads active", r, 32'h3);
  endtask

  task automatic t_pd();
    @(negedge pclk); pd_req = 1;
    @(negedge pclk);
    chk("R8 enable cleared", 32'(pll_enable), 0);
    chk("R8 connect cleared", 32'(pll_connect), 0);
    pd_req = 0;
    repeat (3) @(negedge pclk);
    chk("R8 enable stays off", 32'(pll_enable), 0);
    feed();
    chk("R8 re-enable by feed", 32'(pll_enable), 1);
    chk("R7 fresh enable holds connect off", 32'(pll_connect), 0);
    feed();
    chk("R7 connect on second feed", 32'(pll_connect), 1);
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      total++; fails++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", total - fails, total);
      $finish;
    end
  end

  initial begin
    presetn = 0; psel = 0; penable = 0; pwrite = 0; paddr = '0; pwdata = '0;
    pll_lock = 0; pd_req = 0;
    repeat (3) @(negedge pclk);
    presetn = 1;
    repeat (3) @(negedge pclk);
    t_reset();
    t_shadow();
    t_feed();
    t_abort();
    t_badval();
    t_connect();
    t_pd();
    done = 1;
    $display("%0d/%0d checks passed", total - fails, total);
    $finish;
  end

endmodule